// File: doc/BRIEF.md
# IDE PIO Cycle Timing Controller

This block sits between a simple host request port and one legacy parallel ATA channel. It turns each host read or write of a legacy I/O address into a single programmed-I/O bus cycle: chip selects and device address settle first, then the read or write strobe is held low for a programmed number of clocks, and finally a recovery gap runs before the next cycle may start. A 16-bit configuration word selects the channel, turns the function on and off, and holds one fast timing bank that both attached drives share.

Each drive has its own small control group. It chooses whether the drive runs on the shared fast bank or on the fixed slow compatible timing, whether the device ready line may stretch the strobe, and whether data-port writes are posted. The block watches host writes to the device/head register, so later cycles know which drive is being addressed. The drive interrupt is routed to the interrupt output that matches the selected channel.

Top module: `ide_pio_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x0000, both strobes and both chip selects are high (inactive), `req_ready` is 1, `rsp_valid` is 0 and both interrupt outputs are 0.
- R2: A clock edge with `cfg_we` high loads `cfg_wdata` into the configuration word, which `cfg_q` shows from the next cycle. Field layout: bit 15 function enable; bit 14 channel (0 primary, 1 secondary); bits 13:12 sample field; bits 9:8 recovery field; drive d uses bits 4d+2:4d (bit 4d fast-bank select, bit 4d+1 ready-line use, bit 4d+2 write posting).
- R3: With the function enabled, channel 0 decodes 0x1F0–0x1F7 (chip select 0 low, device address = address bits 2:0) and 0x3F6 (chip select 1 low, device address 6). Channel 1 decodes 0x170–0x177 and 0x376 in the same way. At most one chip select is low at a time.
- R4: An accepted request whose address is not decoded, or any request while bit 15 is 0, makes no strobe. `rsp_valid` is 1 in the cycle after acceptance, a read returns 0xFFFF there, and `req_ready` stays 1.
- R5: `irq_pri` follows `ide_intrq` when enabled with channel 0, `irq_sec` follows it when enabled with channel 1; otherwise both are 0.
- R6: For a drive whose fast-bank bit is 1, a cycle has one setup clock, then a strobe of 5 − sample-field clocks, then 4 − recovery-field clocks of recovery with `req_ready` low.
- R7: For a drive whose fast-bank bit is 0, the strobe lasts 6 clocks and recovery 4 clocks, whatever the bank fields hold.
- R8: A decoded command-block write to offset 6 latches bit 4 of the write data as the current drive (reset value 0). The new drive governs the cycles that follow, not that write itself.
- R9: When the addressed drive's ready-line bit is 1 and `ide_iordy` is low at the last strobe clock, the strobe is held until `ide_iordy` is seen high, and recovery starts after that. When the bit is 0, `ide_iordy` has no effect on the cycle length.
- R10: A read drives `ide_dior_n` low, captures `ide_dd_in` at the last strobe clock, and returns it on `rsp_rdata` with a one-cycle `rsp_valid` in the first recovery cycle.
- R11: A write drives `ide_diow_n` low, with `ide_dd_out` equal to the write data and `ide_dd_oe` high during the strobe. Unless posted, its one-cycle `rsp_valid` comes in the first recovery cycle.
- R12: A write to command-block offset 0 for a drive whose posting bit is 1 gives its `rsp_valid` in the cycle after acceptance. The bus cycle still runs with the same timing, and no second response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 16 | Configuration word write data |
| cfg_q | output | 16 | Current configuration word |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Host I/O address |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data returned |
| ide_cs0_n | output | 1 | Command-block chip select, active low |
| ide_cs1_n | output | 1 | Control-block chip select, active low |
| ide_da | output | 3 | Device register address |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | 16 | Data driven to the drive |
| ide_dd_oe | output | 1 | Data output enable |
| ide_dd_in | input | 16 | Data from the drive |
| ide_iordy | input | 1 | Device ready line |
| ide_intrq | input | 1 | Drive interrupt request |
| irq_pri | output | 1 | Interrupt for the primary channel |
| irq_sec | output | 1 | Interrupt for the secondary channel |

## Verification
The bench builds the block with its defaults: slow strobe 6, slow recovery 4, drive-group stride 4 and device/head drive bit 4. With those values the slow timing is longer than every fast setting, so a cycle that wrongly falls back to the slow path, or wrongly uses the fast bank, shows up as a different strobe count. The stride of 4 keeps the two drive groups apart, so each drive's fast, ready-line and posting bits can be set independently and checked through the drive-select snoop.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int CFG_W = 16;
    localparam int CNT_W = 4;

    localparam logic [15:0] PRI_CMD_BASE = 16'h01F0;
    localparam logic [15:0] PRI_CTL_ADDR = 16'h03F6;
    localparam logic [15:0] SEC_CMD_BASE = 16'h0170;
    localparam logic [15:0] SEC_CTL_ADDR = 16'h0376;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_WAIT,
        SQ_RECOV
    } seq_state_e;

    typedef struct packed {
        logic             en;
        logic             sec;
        logic [1:0]       smp;
        logic [1:0]       rec;
        logic [1:0]       fast;
        logic [1:0]       rdy;
        logic [1:0]       post;
    } cfg_t;

    typedef struct packed {
        logic             hit;
        logic             ctl;
        logic [2:0]       da;
        logic             devhead;
        logic             dataport;
    } dec_t;

    typedef struct packed {
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] recov;
        logic             use_rdy;
    } tim_t;

    function automatic tim_t pick_timing(
        input logic             fast,
        input logic             rdy_en,
        input logic [1:0]       smp,
        input logic [1:0]       rec,
        input logic [CNT_W-1:0] slow_s,
        input logic [CNT_W-1:0] slow_r
    );
        tim_t t;
        t.use_rdy = rdy_en;
        if (fast) begin
            t.strobe = CNT_W'(5) - CNT_W'(smp);
            t.recov  = CNT_W'(4) - CNT_W'(rec);
        end else begin
            t.strobe = slow_s;
            t.recov  = slow_r;
        end
        return t;
    endfunction

endpackage

// File: rtl/ide_cfg_reg.sv
module ide_cfg_reg
    import ide_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/ide_addr_dec.sv
module ide_addr_dec
    import ide_pio_pkg::*;
(
    input  logic        en,
    input  logic        sec,
    input  logic [15:0] addr,
    input  logic        intrq,
    output dec_t        dec,
    output logic        irq_pri,
    output logic        irq_sec
);

    logic [15:0] cmd_base;
    logic [15:0] ctl_addr;
    logic        cmd_hit;
    logic        ctl_hit;

    always_comb begin
        cmd_base = sec ? SEC_CMD_BASE : PRI_CMD_BASE;
        ctl_addr = sec ? SEC_CTL_ADDR : PRI_CTL_ADDR;
        cmd_hit  = en && (addr[15:3] == cmd_base[15:3]);
        ctl_hit  = en && (addr == ctl_addr);

        dec.hit      = cmd_hit || ctl_hit;
        dec.ctl      = ctl_hit;
        dec.da       = ctl_hit ? 3'd6 : addr[2:0];
        dec.devhead  = cmd_hit && (addr[2:0] == 3'd6);
        dec.dataport = cmd_hit && (addr[2:0] == 3'd0);
    end

    assign irq_pri = en && !sec && intrq;
    assign irq_sec = en &&  sec && intrq;

endmodule

// File: rtl/ide_cycle_seq.sv
module ide_cycle_seq
    import ide_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        null_acc,
    input  logic        write,
    input  logic [15:0] wdata,
    input  tim_t        tim,
    input  logic        post,
    input  logic        ctl,
    input  logic [2:0]  da,
    input  logic        iordy,
    input  logic [15:0] dd_in,
    output logic        idle,
    output logic        cs0_n,
    output logic        cs1_n,
    output logic [2:0]  da_out,
    output logic        dior_n,
    output logic        diow_n,
    output logic [15:0] dd_out,
    output logic        dd_oe,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata
);

    localparam int LEN_W = CNT_W + 4;

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    tim_t             l_tim;
    logic             l_wr;
    logic [15:0]      l_wd;
    logic             l_ctl;
    logic [2:0]       l_da;
    logic             l_post;
    logic             strobe_on;
    logic             in_rec;
    logic             active;

    assign strobe_on = (state == SQ_STROBE) || (state == SQ_WAIT);
    assign in_rec    = (state == SQ_RECOV);
    assign active    = (state == SQ_SETUP) || strobe_on;
    assign idle      = (state == SQ_IDLE);

    assign cs0_n  = !(active && !l_ctl);
    assign cs1_n  = !(active &&  l_ctl);
    assign da_out = l_da;
    assign dior_n = !(strobe_on && !l_wr);
    assign diow_n = !(strobe_on &&  l_wr);
    assign dd_out = l_wd;
    assign dd_oe  = active && l_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            l_tim     <= '0;
            l_wr      <= 1'b0;
            l_wd      <= '0;
            l_ctl     <= 1'b0;
            l_da      <= '0;
            l_post    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state  <= SQ_SETUP;
                        l_tim  <= tim;
                        l_wr   <= write;
                        l_wd   <= wdata;
                        l_ctl  <= ctl;
                        l_da   <= da;
                        l_post <= post && write;
                        if (post && write) begin
                            rsp_valid <= 1'b1;
                        end
                    end else if (null_acc) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= '1;
                    end
                end
                SQ_SETUP: begin
                    state <= SQ_STROBE;
                    cnt   <= l_tim.strobe - 1'b1;
                end
                SQ_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (l_tim.use_rdy && !iordy) begin
                        state <= SQ_WAIT;
                    end else begin
                        state <= SQ_RECOV;
                        cnt   <= l_tim.recov - 1'b1;
                        if (!l_wr) rsp_rdata <= dd_in;
                        if (!l_post) rsp_valid <= 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (iordy) begin
                        state <= SQ_RECOV;
                        cnt   <= l_tim.recov - 1'b1;
                        if (!l_wr) rsp_rdata <= dd_in;
                        if (!l_post) rsp_valid <= 1'b1;
                    end
                end
                SQ_RECOV: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Length counters observed by the assertions below
    logic [LEN_W-1:0] strobe_len;
    logic [LEN_W-1:0] rec_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_len <= '0;
            rec_len    <= '0;
        end else begin
            if (strobe_on) begin
                if (strobe_len != '1) strobe_len <= strobe_len + 1'b1;
            end else begin
                strobe_len <= '0;
            end
            if (in_rec) begin
                if (rec_len != '1) rec_len <= rec_len + 1'b1;
            end else begin
                rec_len <= '0;
            end
        end
    end

    a_r6_strobe_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_on) && !l_tim.use_rdy) |-> (strobe_len == LEN_W'(l_tim.strobe)));

    a_r9_strobe_min: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_on) |-> (strobe_len >= LEN_W'(l_tim.strobe)));

    a_r6_recov_len: assert property (@(posedge clk) disable iff (rst)
        $fell(in_rec) |-> (rec_len == LEN_W'(l_tim.recov)));

    a_r10_rsp_at_end: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_on) && !l_post) |-> rsp_valid);

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    a_r3_cs_excl: assert property (@(posedge clk) disable iff (rst)
        !(!cs0_n && !cs1_n));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        idle |-> (dior_n && diow_n));

endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
    import ide_pio_pkg::*;
#(
    parameter int SLOW_STROBE = 6,
    parameter int SLOW_RECOV  = 4,
    parameter int GRP_STRIDE  = 4,
    parameter int DRV_BIT     = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_q,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_addr,
    input  logic        req_write,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        ide_cs0_n,
    output logic        ide_cs1_n,
    output logic [2:0]  ide_da,
    output logic        ide_dior_n,
    output logic        ide_diow_n,
    output logic [15:0] ide_dd_out,
    output logic        ide_dd_oe,
    input  logic [15:0] ide_dd_in,
    input  logic        ide_iordy,
    input  logic        ide_intrq,
    output logic        irq_pri,
    output logic        irq_sec
);

    localparam int NUM_DRV = 2;

    cfg_t  cfg;
    dec_t  dec;
    tim_t  tim;
    logic  drv_q;
    logic  accept;
    logic  idle;

    ide_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    assign cfg.en  = cfg_q[15];
    assign cfg.sec = cfg_q[14];
    assign cfg.smp = cfg_q[13:12];
    assign cfg.rec = cfg_q[9:8];

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        assign cfg.fast[d] = cfg_q[GRP_STRIDE*d];
        assign cfg.rdy[d]  = cfg_q[GRP_STRIDE*d + 1];
        assign cfg.post[d] = cfg_q[GRP_STRIDE*d + 2];
    end

    ide_addr_dec u_dec (
        .en      (cfg.en),
        .sec     (cfg.sec),
        .addr    (req_addr),
        .intrq   (ide_intrq),
        .dec     (dec),
        .irq_pri (irq_pri),
        .irq_sec (irq_sec)
    );

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= 1'b0;
        end else if (accept && dec.devhead && req_write) begin
            drv_q <= req_wdata[DRV_BIT];
        end
    end

    assign tim = pick_timing(cfg.fast[drv_q], cfg.rdy[drv_q], cfg.smp, cfg.rec,
                             CNT_W'(SLOW_STROBE), CNT_W'(SLOW_RECOV));

    ide_cycle_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && dec.hit),
        .null_acc  (accept && !dec.hit),
        .write     (req_write),
        .wdata     (req_wdata),
        .tim       (tim),
        .post      (cfg.post[drv_q] && dec.dataport),
        .ctl       (dec.ctl),
        .da        (dec.da),
        .iordy     (ide_iordy),
        .dd_in     (ide_dd_in),
        .idle      (idle),
        .cs0_n     (ide_cs0_n),
        .cs1_n     (ide_cs1_n),
        .da_out    (ide_da),
        .dior_n    (ide_dior_n),
        .diow_n    (ide_diow_n),
        .dd_out    (ide_dd_out),
        .dd_oe     (ide_dd_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    a_r5_irq_excl: assert property (@(posedge clk) disable iff (rst)
        !(irq_pri && irq_sec));

endmodule

// File: tb/sim_ide_pio_ctrl.sv
module sim_ide_pio_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        ide_cs0_n, ide_cs1_n;
    logic [2:0]  ide_da;
    logic        ide_dior_n, ide_diow_n;
    logic [15:0] ide_dd_out;
    logic        ide_dd_oe;
    logic [15:0] ide_dd_in = '0;
    logic        ide_iordy = 1'b1;
    logic        ide_intrq = 1'b0;
    logic        irq_pri, irq_sec;

    always #10 clk = ~clk;   // 50 MHz

    ide_pio_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
        .ide_da(ide_da), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
        .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe), .ide_dd_in(ide_dd_in),
        .ide_iordy(ide_iordy), .ide_intrq(ide_intrq), .irq_pri(irq_pri), .irq_sec(irq_sec)
    );

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    logic [15:0] m_cfg = '0;
    bit   m_drv = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit bdec(input logic [15:0] a, input logic [15:0] c,
                                output bit ctl, output bit [2:0] da);
        logic [15:0] cb;
        logic [15:0] ca;
        cb  = c[14] ? 16'h0170 : 16'h01F0;
        ca  = c[14] ? 16'h0376 : 16'h03F6;
        ctl = 0;
        da  = a[2:0];
        if (!c[15]) return 0;
        if (a[15:3] == cb[15:3]) return 1;
        if (a == ca) begin
            ctl = 1;
            da  = 3'd6;
            return 1;
        end
        return 0;
    endfunction

    function automatic int exp_strobe(input logic [15:0] c, input bit d);
        if (c[4*d]) return 5 - int'(c[13:12]);
        return 6;
    endfunction

    function automatic int exp_recov(input logic [15:0] c, input bit d);
        if (c[4*d]) return 4 - int'(c[9:8]);
        return 4;
    endfunction

    task automatic do_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
        m_cfg = v;
        chk(cfg_q == v, "R2 cfg readback", cfg_q, v);
    endtask

    task automatic do_access(input logic [15:0] addr, input bit wr, input logic [15:0] wd,
                             input int wcyc, input string note);
        bit       ctl;
        bit [2:0] da;
        bit       hit;
        bit       d;
        bit       rdy_en;
        bit       post;
        int       s, r, exp_s, exp_rsp;
        int       n, strobe_cnt, rec_cnt, rsp_n, rsp_idx;
        logic [15:0] din;
        logic [15:0] got_data;
        string    tg;

        hit    = bdec(addr, m_cfg, ctl, da);
        d      = m_drv;
        rdy_en = m_cfg[4*d + 1];
        post   = wr && m_cfg[4*d + 2] && hit && !ctl && (da == 3'd0);
        s      = exp_strobe(m_cfg, d);
        r      = exp_recov(m_cfg, d);
        exp_s  = s + (rdy_en ? wcyc : 0);
        exp_rsp = post ? 1 : 2 + exp_s;
        tg = m_cfg[4*d] ? "R6" : "R7";
        if (wcyc > 0) tg = {tg, " R9"};
        din = 16'($urandom);

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = addr; req_write = wr; req_wdata = wd;
        ide_dd_in = din;
        ide_iordy = (wcyc == 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;

        if (!hit) begin
            chk(rsp_valid == 1'b1, {"R4 null rsp ", note}, rsp_valid, 1);
            if (!wr) chk(rsp_rdata == 16'hFFFF, {"R4 null data ", note}, rsp_rdata, 16'hFFFF);
            chk(ide_dior_n && ide_diow_n, {"R4 no strobe ", note}, {ide_dior_n, ide_diow_n}, 3);
            chk(req_ready == 1'b1, {"R4 ready ", note}, req_ready, 1);
            ide_iordy = 1;
            return;
        end

        n = 1; strobe_cnt = 0; rec_cnt = 0; rsp_n = 0; rsp_idx = 0; got_data = '0;
        while (n < 100) begin
            if (!ide_dior_n || !ide_diow_n) begin
                strobe_cnt++;
                if (strobe_cnt == 1) begin
                    chk(ide_cs0_n == ctl && ide_cs1_n == !ctl, {"R3 chip select ", note},
                        {ide_cs0_n, ide_cs1_n}, {ctl, !ctl});
                    chk(ide_da == da, {"R3 device addr ", note}, ide_da, da);
                    if (wr) begin
                        chk(!ide_diow_n && ide_dior_n, {"R11 write strobe ", note},
                            {ide_dior_n, ide_diow_n}, 2);
                        chk(ide_dd_oe && ide_dd_out == wd, {"R11 write data ", note},
                            ide_dd_out, wd);
                    end else begin
                        chk(!ide_dior_n && ide_diow_n && !ide_dd_oe, {"R10 read strobe ", note},
                            {ide_dior_n, ide_diow_n}, 1);
                    end
                end
                if (strobe_cnt == s + wcyc) ide_iordy = 1;
            end else if (strobe_cnt > 0 && !req_ready) begin
                rec_cnt++;
            end
            if (rsp_valid) begin
                rsp_n++;
                rsp_idx  = n;
                got_data = rsp_rdata;
            end
            if (req_ready) break;
            @(negedge clk);
            n++;
        end
        ide_iordy = 1;

        chk(strobe_cnt == exp_s, {tg, " strobe length ", note}, strobe_cnt, exp_s);
        chk(rec_cnt == r, {tg, " recovery length ", note}, rec_cnt, r);
        chk(rsp_n == 1, {"R12 single response ", note}, rsp_n, 1);
        chk(rsp_idx == exp_rsp, {post ? "R12" : (wr ? "R11" : "R10"), " response cycle ", note},
            rsp_idx, exp_rsp);
        if (!wr) chk(got_data == din, {"R10 read data ", note}, got_data, din);

        if (wr && !ctl && da == 3'd6) m_drv = wd[4];
    endtask

    task automatic chk_irq(input string note);
        bit ep, es;
        @(negedge clk);
        ide_intrq = 1;
        #1;
        ep = m_cfg[15] && !m_cfg[14];
        es = m_cfg[15] &&  m_cfg[14];
        chk(irq_pri == ep && irq_sec == es, {"R5 irq route ", note}, {irq_pri, irq_sec}, {ep, es});
        ide_intrq = 0;
        #1;
        chk(!irq_pri && !irq_sec, {"R5 irq low ", note}, {irq_pri, irq_sec}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cfg_q == 16'h0, "R1 cfg reset", cfg_q, 0);
        chk(ide_dior_n && ide_diow_n && ide_cs0_n && ide_cs1_n, "R1 bus idle",
            {ide_dior_n, ide_diow_n, ide_cs0_n, ide_cs1_n}, 4'hF);
        chk(req_ready && !rsp_valid, "R1 handshake", {req_ready, rsp_valid}, 2);
        chk(!irq_pri && !irq_sec, "R1 irq", {irq_pri, irq_sec}, 0);
        rst = 0;

        // Disabled: nothing decodes
        do_access(16'h01F0, 0, 16'h0, 0, "disabled");
        chk_irq("disabled");

        // Fast bank, slowest fast setting, with and without ready stretch
        do_cfg(16'h8003);
        do_access(16'h01F0, 0, 16'h0, 0, "fast max");
        do_access(16'h01F2, 0, 16'h0, 2, "fast wait");
        do_access(16'h01F3, 1, 16'hA55A, 0, "fast write");
        // Fastest fast setting
        do_cfg(16'hB301);
        do_access(16'h01F3, 0, 16'h0, 0, "fast min");
        do_access(16'h01F4, 1, 16'h1234, 0, "fast min write");
        // Fast bit clear: bank fields ignored
        do_cfg(16'hB300);
        do_access(16'h03F6, 0, 16'h0, 0, "slow ctl");
        do_access(16'h01F7, 1, 16'h00FF, 0, "slow write");
        // Ready line disabled: low iordy ignored
        do_cfg(16'h9101);
        do_access(16'h01F1, 0, 16'h0, 2, "iordy off");
        // Drive snoop: drive0 slow, drive1 fast + posting
        do_cfg(16'hA250);
        do_access(16'h01F6, 1, 16'h0010, 0, "R8 select drive1");
        do_access(16'h01F0, 1, 16'hBEEF, 0, "R8 R12 posted");
        do_access(16'h01F0, 0, 16'h0, 0, "R8 read drive1");
        do_access(16'h01F6, 1, 16'h0000, 0, "R8 select drive0");
        do_access(16'h01F0, 1, 16'hCAFE, 0, "R8 drive0 unposted");
        // Secondary channel
        do_cfg(16'hC001);
        do_access(16'h0172, 0, 16'h0, 0, "secondary cmd");
        do_access(16'h0376, 0, 16'h0, 0, "secondary ctl");
        do_access(16'h01F2, 0, 16'h0, 0, "primary miss");
        chk_irq("secondary");
        do_cfg(16'h8001);
        chk_irq("primary");
        do_access(16'h0170, 1, 16'h0, 0, "secondary miss");

        // Random mix
        for (int i = 0; i < 200; i++) begin
            logic [15:0] a;
            logic [15:0] v;
            int          k;
            if (i % 12 == 0) begin
                v = 16'($urandom);
                if ($urandom % 8 != 0) v[15] = 1;
                do_cfg(v);
            end
            k = $urandom % 6;
            case (k)
                0, 1: a = 16'h01F0 + 16'($urandom % 8);
                2:    a = 16'h03F6;
                3:    a = 16'h0170 + 16'($urandom % 8);
                4:    a = 16'h0376;
                default: a = 16'($urandom);
            endcase
            do_access(a, 1'($urandom), 16'($urandom), int'($urandom % 3), "random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule